// File: doc/BRIEF.md
# Tagged Response Buffer Loader

This block sits between a message backend and the output buffer of a byte-wide host mailbox controller. Each request the controller sends to the backend carries the current waiting tag, which the block exports. When the backend answers, it streams the response one byte per beat. The first beat carries the tag and the total response length. The block accepts the response only if its tag equals the waiting tag. It then writes the bytes into the output buffer through a simple write port and advances the tag, so that a second copy of the same response finds a stale tag and is dropped.

An abort from the controller also advances the waiting tag. Any response still in flight is therefore ignored, and a response that is part-way through loading stops at once. A response longer than the output buffer is not stored in full. The buffer instead receives its first two bytes followed by a fixed completion code that reports that the requested byte count cannot be returned, and the stored length becomes three.

When the final beat of an accepted response has been taken, the block publishes the stored length, sets the read position, and raises a one-cycle handshake. This handshake puts the controller into its read state with the first byte already presented on a data-out strobe. A request dispatch clears the read position and the stored length.

Top module: `rsp_loader`

## Requirements
- R1: After reset the waiting tag `req_tag` is 0, `out_len` and `out_pos` are 0, and `read_go` and `dout_valid` are low.
- R2: A beat with `rsp_sop` high whose `rsp_tag` differs from `req_tag` is rejected. Neither it nor any later beat up to its `rsp_eop` produces a buffer write, and `req_tag`, `out_len` and `out_pos` are unchanged.
- R3: A start beat whose tag matches, with `abort` low, is accepted. `req_tag` increases by one at the next clock, so a duplicate response with the same tag is rejected.
- R4: Each cycle with `abort` high increases `req_tag` by one. A start beat in that cycle is rejected. An accepted response still streaming stops writing from that beat on and never completes.
- R5: For an accepted response with `rsp_len` no larger than DEPTH, beat i (counted from 0 at the start beat) writes `rsp_data` to address i for every i below `rsp_len`, and the stored length equals `rsp_len`. A response occupies max(1, `rsp_len`) beats.
- R6: For an accepted response with `rsp_len` greater than DEPTH, only three writes occur: beat 0 to address 0, beat 1 to address 1, and the value 0xCA to address 2. The stored length is 3.
- R7: One cycle after the final beat of an accepted response, `read_go` pulses for one cycle, and `out_len` shows the stored length. If that length is nonzero, `out_pos` is 1 and `dout_valid` pulses with `dout_byte` equal to the stored byte at address 0. Otherwise `out_pos` is 0 and `dout_valid` stays low.
- R8: A cycle with `dispatch` high and no completion sets `out_len` and `out_pos` to 0 at the next clock.
- R9: The waiting tag is TAGW bits wide and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispatch | input | 1 | A new request is being sent to the backend |
| abort | input | 1 | Controller abort; invalidates the outstanding request |
| req_tag | output | TAGW | Current waiting tag, attached to each request |
| rsp_valid | input | 1 | A response beat is present |
| rsp_sop | input | 1 | First beat of a response (tag and length are valid) |
| rsp_eop | input | 1 | Final beat of a response |
| rsp_tag | input | TAGW | Tag of the response, sampled on the start beat |
| rsp_len | input | LENW | Total response length in bytes, sampled on the start beat |
| rsp_data | input | 8 | Response byte carried by this beat |
| obuf_we | output | 1 | Output buffer write strobe |
| obuf_addr | output | AW | Output buffer write address |
| obuf_wdata | output | 8 | Output buffer write data |
| out_len | output | LW | Stored response length |
| out_pos | output | LW | Read position handed to the controller |
| read_go | output | 1 | One-cycle pulse: enter the read state |
| dout_valid | output | 1 | One-cycle pulse: first byte is presented |
| dout_byte | output | 8 | First stored byte |

## Verification
The loading path is exercised with a short response, a response exactly as long as the buffer, responses one byte too long and far too long, and a zero-length response. These show where the copy ends, where truncation starts, and how the handshake behaves with nothing to deliver. Tag handling is tried with a duplicate of an accepted response, an unrelated tag, an abort before a stale response, an abort in the same cycle as a matching start beat, and an abort in the middle of an accepted stream. Together these separate accept-time tag changes from abort-time ones. A long run of aborts drives the tag to its maximum so that the wrap to zero is seen on an accepted response.

// File: rtl/lr_pkg.sv
package lr_pkg;

  // completion code: requested byte count cannot be returned
  localparam logic [7:0] CC_TOO_LONG = 8'hCA;

  // number of bytes kept in the output buffer for a response of len bytes
  function automatic int unsigned kept_len(int unsigned len, int unsigned depth);
    return (len > depth) ? 3 : len;
  endfunction

  // whether beat idx produces a buffer write
  function automatic logic beat_kept(int unsigned idx, int unsigned len, logic trunc);
    return trunc ? (idx < 3) : (idx < len);
  endfunction

  // value written for beat idx
  function automatic logic [7:0] beat_byte(int unsigned idx, logic [7:0] d, logic trunc);
    return (trunc && idx == 2) ? CC_TOO_LONG : d;
  endfunction

endpackage

// File: rtl/lr_tag_track.sv
module lr_tag_track #(
  parameter int TAGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            sop_beat,
  input  logic [TAGW-1:0] rsp_tag,
  output logic [TAGW-1:0] wtag,
  output logic            accept
);

  logic [TAGW-1:0] tag_q;

  assign accept = sop_beat && !abort && (rsp_tag == tag_q);
  assign wtag   = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (abort || accept) begin
      tag_q <= tag_q + 1'b1;
    end
  end

endmodule

// File: rtl/lr_beat_writer.sv
module lr_beat_writer #(
  parameter int DEPTH = 32,
  parameter int LENW  = 8,
  parameter int AW    = 5,
  parameter int LW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic            sop,
  input  logic            eop,
  input  logic            abort,
  input  logic            accept,
  input  logic [7:0]      data,
  input  logic [LENW-1:0] len,
  output logic            we,
  output logic [AW-1:0]   addr,
  output logic [7:0]      wdata,
  output logic            done,
  output logic            trunc_now,
  output logic [LW-1:0]   kept,
  output logic [7:0]      byte0
);

  logic            active_q;
  logic            trunc_q;
  logic [LENW-1:0] len_q;
  logic [LENW-1:0] idx_q;
  logic [7:0]      byte0_q;

  logic            in_msg;
  logic            take;
  logic [LENW-1:0] cur_idx;
  logic [LENW-1:0] cur_len;

  always_comb begin
    in_msg    = sop ? accept : (active_q && !abort);
    cur_idx   = sop ? '0 : idx_q;
    cur_len   = sop ? len : len_q;
    trunc_now = sop ? (32'(len) > 32'(DEPTH)) : trunc_q;
    take      = beat && in_msg;
    we        = take && lr_pkg::beat_kept(32'(cur_idx), 32'(cur_len), trunc_now);
    addr      = cur_idx[AW-1:0];
    wdata     = lr_pkg::beat_byte(32'(cur_idx), data, trunc_now);
    done      = take && eop;
    kept      = LW'(lr_pkg::kept_len(32'(cur_len), 32'(DEPTH)));
    byte0     = sop ? data : byte0_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      trunc_q  <= 1'b0;
      len_q    <= '0;
      idx_q    <= '0;
      byte0_q  <= '0;
    end else begin
      if (abort) begin
        active_q <= 1'b0;
      end else if (take) begin
        active_q <= !eop;
      end
      if (take) begin
        idx_q <= cur_idx + 1'b1;
      end
      if (beat && sop && accept) begin
        len_q   <= len;
        trunc_q <= trunc_now;
        byte0_q <= data;
      end
    end
  end

endmodule

// File: rtl/lr_read_launch.sv
module lr_read_launch #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          dispatch,
  input  logic [LW-1:0] kept,
  input  logic [7:0]    byte0,
  output logic [LW-1:0] out_len,
  output logic [LW-1:0] out_pos,
  output logic          read_go,
  output logic          dout_valid,
  output logic [7:0]    dout_byte
);

  logic has_bytes;
  assign has_bytes = (kept != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_len    <= '0;
      out_pos    <= '0;
      read_go    <= 1'b0;
      dout_valid <= 1'b0;
      dout_byte  <= '0;
    end else begin
      read_go    <= done;
      dout_valid <= done && has_bytes;
      if (done) begin
        out_len <= kept;
        out_pos <= has_bytes ? LW'(1) : '0;
        if (has_bytes) begin
          dout_byte <= byte0;
        end
      end else if (dispatch) begin
        out_len <= '0;
        out_pos <= '0;
      end
    end
  end

endmodule

// File: rtl/rsp_loader.sv
module rsp_loader #(
  parameter int DEPTH = 32,
  parameter int LENW  = 8,
  parameter int TAGW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dispatch,
  input  logic            abort,
  output logic [TAGW-1:0] req_tag,
  input  logic            rsp_valid,
  input  logic            rsp_sop,
  input  logic            rsp_eop,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [LENW-1:0] rsp_len,
  input  logic [7:0]      rsp_data,
  output logic            obuf_we,
  output logic [AW-1:0]   obuf_addr,
  output logic [7:0]      obuf_wdata,
  output logic [LW-1:0]   out_len,
  output logic [LW-1:0]   out_pos,
  output logic            read_go,
  output logic            dout_valid,
  output logic [7:0]      dout_byte
);

  // named internal events, observed by the bound checker
  logic          accept_evt;
  logic          done_evt;
  logic          trunc_now;
  logic [LW-1:0] kept;
  logic [7:0]    byte0;

  lr_tag_track #(.TAGW(TAGW)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .sop_beat (rsp_valid && rsp_sop),
    .rsp_tag  (rsp_tag),
    .wtag     (req_tag),
    .accept   (accept_evt)
  );

  lr_beat_writer #(.DEPTH(DEPTH), .LENW(LENW), .AW(AW), .LW(LW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (rsp_valid),
    .sop       (rsp_sop),
    .eop       (rsp_eop),
    .abort     (abort),
    .accept    (accept_evt),
    .data      (rsp_data),
    .len       (rsp_len),
    .we        (obuf_we),
    .addr      (obuf_addr),
    .wdata     (obuf_wdata),
    .done      (done_evt),
    .trunc_now (trunc_now),
    .kept      (kept),
    .byte0     (byte0)
  );

  lr_read_launch #(.LW(LW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done_evt),
    .dispatch   (dispatch),
    .kept       (kept),
    .byte0      (byte0),
    .out_len    (out_len),
    .out_pos    (out_pos),
    .read_go    (read_go),
    .dout_valid (dout_valid),
    .dout_byte  (dout_byte)
  );

endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
  parameter int DEPTH = 32,
  parameter int TAGW  = 8,
  parameter int LW    = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dispatch,
  input logic            abort,
  input logic            rsp_valid,
  input logic            rsp_sop,
  input logic [TAGW-1:0] rsp_tag,
  input logic [TAGW-1:0] req_tag,
  input logic            obuf_we,
  input logic [LW-1:0]   out_len,
  input logic [LW-1:0]   out_pos,
  input logic            read_go,
  input logic            dout_valid,
  input logic            accept_evt,
  input logic            done_evt,
  input logic            trunc_now
);

  AST_REJECT_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sop && !abort && rsp_tag != req_tag) |=> (req_tag == $past(req_tag))); // R2

  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sop && rsp_tag != req_tag) |-> !obuf_we); // R2

  AST_ACCEPT_BUMPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (req_tag == TAGW'($past(req_tag) + 1'b1))); // R3

  AST_ABORT_BUMPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (req_tag == TAGW'($past(req_tag) + 1'b1))); // R4

  AST_FIT_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (32'(out_len) <= DEPTH)); // R5

  AST_TRUNC_LEN_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && trunc_now) |=> (out_len == LW'(3))); // R6

  AST_DONE_RAISES_GO: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> read_go); // R7

  AST_DOUT_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (read_go && out_pos == LW'(1) && out_len != '0)); // R7

  AST_DISPATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && !done_evt) |=> (out_len == '0 && out_pos == '0)); // R8

endmodule

bind rsp_loader lr_checker #(.DEPTH(DEPTH), .TAGW(TAGW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dispatch   (dispatch),
  .abort      (abort),
  .rsp_valid  (rsp_valid),
  .rsp_sop    (rsp_sop),
  .rsp_tag    (rsp_tag),
  .req_tag    (req_tag),
  .obuf_we    (obuf_we),
  .out_len    (out_len),
  .out_pos    (out_pos),
  .read_go    (read_go),
  .dout_valid (dout_valid),
  .accept_evt (accept_evt),
  .done_evt   (done_evt),
  .trunc_now  (trunc_now)
);

// File: tb/test_rsp_loader.sv
`timescale 1ns/1ps
module test_rsp_loader;

  localparam int DEPTH = 32;
  localparam int LENW  = 8;
  localparam int TAGW  = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dispatch = 1'b0, abort = 1'b0;
  logic rsp_valid = 1'b0, rsp_sop = 1'b0, rsp_eop = 1'b0;
  logic [TAGW-1:0] rsp_tag = '0;
  logic [LENW-1:0] rsp_len = '0;
  logic [7:0] rsp_data = '0;
  logic [TAGW-1:0] req_tag;
  logic obuf_we;
  logic [AW-1:0] obuf_addr;
  logic [7:0] obuf_wdata;
  logic [LW-1:0] out_len, out_pos;
  logic read_go, dout_valid;
  logic [7:0] dout_byte;

  always #5 clk = ~clk;

  rsp_loader #(.DEPTH(DEPTH), .LENW(LENW), .TAGW(TAGW)) i_rsp_loader (
    .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .abort(abort), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_sop(rsp_sop), .rsp_eop(rsp_eop), .rsp_tag(rsp_tag),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .obuf_we(obuf_we), .obuf_addr(obuf_addr),
    .obuf_wdata(obuf_wdata), .out_len(out_len), .out_pos(out_pos), .read_go(read_go),
    .dout_valid(dout_valid), .dout_byte(dout_byte)
  );

  int checks = 0;
  int errors = 0;
  int qa[$];
  int qd[$];
  int mtag = 0;
  int exp_len = 0;
  int exp_pos = 0;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // monitor: every buffer write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && obuf_we) begin
      checks++;
      if (qa.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected write actual addr %0d data %0h expected none",
                 obuf_addr, obuf_wdata);
      end else begin
        int a, d;
        a = qa.pop_front();
        d = qd.pop_front();
        if (int'(obuf_addr) != a || int'(obuf_wdata) != d) begin
          errors++;
          $display("FAIL R5/R6 write actual %0d:%0h expected %0d:%0h",
                   obuf_addr, obuf_wdata, a, d);
        end
      end
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return base + 8'(i * 7);
  endfunction

  // driver: streams one response and pushes the expected writes
  task automatic send_rsp(input int tag, input int len, input logic [7:0] base,
                          input int abort_at, input string rq);
    int  nb;
    bit  acc;
    bit  trunc;
    int  kept;
    nb    = (len == 0) ? 1 : len;
    acc   = (tag == mtag) && (abort_at != 0);
    trunc = (len > DEPTH);
    kept  = trunc ? 3 : len;
    if (acc) begin
      for (int i = 0; i < nb; i++) begin
        if (abort_at >= 0 && i >= abort_at) break;
        if (trunc) begin
          if (i < 2) begin qa.push_back(i); qd.push_back(int'(pat(base, i))); end
          else if (i == 2) begin qa.push_back(2); qd.push_back(8'hCA); end
        end else if (i < len) begin
          qa.push_back(i); qd.push_back(int'(pat(base, i)));
        end
      end
      mtag = (mtag + 1) % 256;
    end
    if (abort_at >= 0) mtag = (mtag + 1) % 256;
    for (int i = 0; i < nb; i++) begin
      @(posedge clk); #1;
      rsp_valid = 1'b1;
      rsp_sop   = (i == 0);
      rsp_eop   = (i == nb - 1);
      rsp_tag   = TAGW'(tag);
      rsp_len   = LENW'(len);
      rsp_data  = pat(base, i);
      abort     = (i == abort_at);
    end
    @(posedge clk); #1;
    rsp_valid = 1'b0; rsp_sop = 1'b0; rsp_eop = 1'b0; abort = 1'b0;
    @(negedge clk);
    if (acc && abort_at < 0) begin
      exp_len = kept;
      exp_pos = (kept > 0) ? 1 : 0;
      chk({rq, " R7 read_go"}, int'(read_go), 1);
      chk({rq, " R7 dout_valid"}, int'(dout_valid), (kept > 0) ? 1 : 0);
      if (kept > 0) chk({rq, " R7 dout_byte"}, int'(dout_byte), int'(pat(base, 0)));
    end else begin
      chk({rq, " R2 no read_go"}, int'(read_go), 0);
    end
    chk({rq, " out_len"}, int'(out_len), exp_len);
    chk({rq, " out_pos"}, int'(out_pos), exp_pos);
    chk({rq, " R3 req_tag"}, int'(req_tag), mtag);
    checks++;
    if (qa.size() != 0) begin
      errors++;
      $display("FAIL %s missing writes actual %0d expected 0", rq, qa.size());
      qa.delete(); qd.delete();
    end
  endtask

  task automatic hold_abort(input int n);
    @(posedge clk); #1;
    abort = 1'b1;
    repeat (n) @(posedge clk);
    #1 abort = 1'b0;
    mtag = (mtag + n) % 256;
    @(negedge clk);
    chk("R4 tag after aborts", int'(req_tag), mtag);
  endtask

  task automatic do_dispatch();
    @(posedge clk); #1;
    dispatch = 1'b1;
    @(posedge clk); #1;
    dispatch = 1'b0;
    exp_len = 0; exp_pos = 0;
    @(negedge clk);
    chk("R8 dispatch out_len", int'(out_len), 0);
    chk("R8 dispatch out_pos", int'(out_pos), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_tag", int'(req_tag), 0);
    chk("R1 out_len", int'(out_len), 0);
    chk("R1 out_pos", int'(out_pos), 0);
    chk("R1 read_go", int'(read_go), 0);
    chk("R1 dout_valid", int'(dout_valid), 0);

    send_rsp(0, 5, 8'h10, -1, "R5 short");
    send_rsp(0, 4, 8'h40, -1, "R3 duplicate");
    send_rsp(9, 3, 8'h55, -1, "R2 foreign tag");
    send_rsp(mtag, DEPTH, 8'h20, -1, "R5 exact fit");
    do_dispatch();
    send_rsp(mtag, DEPTH + 1, 8'h30, -1, "R6 one over");
    send_rsp(mtag, 200, 8'h70, -1, "R6 far over");
    send_rsp(mtag, 0, 8'h00, -1, "R7 empty");
    do_dispatch();
    hold_abort(1);
    send_rsp(mtag - 1, 3, 8'h90, -1, "R4 stale after abort");
    send_rsp(mtag, 3, 8'hA0, 0, "R4 abort at start");
    send_rsp(mtag, 8, 8'hB0, 3, "R4 abort mid stream");
    send_rsp(mtag, 2, 8'hC0, -1, "R7 after aborts");
    hold_abort((255 - mtag + 256) % 256);
    chk("R9 tag at max", int'(req_tag), 255);
    send_rsp(255, 2, 8'hD0, -1, "R9 wrap");
    chk("R9 tag wrapped", int'(req_tag), 0);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule